// File: doc/BRIEF.md
# Host/Firmware Doorbell Mailbox

This block is the device side of a two-way mailbox between a host processor and an on-chip firmware engine. It holds two circular buffers of 32-bit slots. One carries dwords from the host to the firmware and the other carries dwords back. The host reaches everything through a small 32-bit register bus with four word addresses. Writing the first address pushes a dword toward the firmware. Reading the second address pops the next dword sent by the firmware. The third address is the host control/status word, and the fourth is a read-only view of the firmware-side buffer. The firmware side uses plain ports: a push strobe with data, a pop strobe with combinational data, a ready level, a doorbell input that interrupts the host, and a doorbell output that the host rings.

Occupancy is not reported as a count. Each status word carries the buffer depth and the raw 8-bit write and read pointers, and software computes the fill as their difference modulo 256. Interrupt status, doorbell generation, the ready flag and the reset handshake all sit in the host control word. A three-state link machine tracks the handshake:

- LNK_IDLE is entered at power-on, on release of reset without ready, and when ready is written to zero.
- LNK_READY is entered on a write with ready=1 and reset=0.
- LNK_RESET is entered on any write with reset=1.

Only the transition into LNK_RESET from another state flushes the buffers.

Top module: `mbx_doorbell`

## Requirements
- R1: Both status words carry the buffer depth in bits 31:24, the write pointer in bits 23:16 and the read pointer in bits 15:8. The host control word is at address 2 and describes the host-to-firmware buffer. The firmware view is at address 3, describes the firmware-to-host buffer, and shows the firmware ready input at bit 3. After reset both words read depth with all other fields zero.
- R2: A bus write to address 0 stores the dword and advances the host-to-firmware write pointer by one. The firmware pops dwords in push order on `fw_pop_data`, and `fw_msg_avail` is high while that buffer holds data.
- R3: A `fw_push` stores the dword in the firmware-to-host buffer. Bus reads of address 1 return the dwords in order, and each read advances that buffer's read pointer by one.
- R4: Pointers advance by one per dword and wrap from 255 to 0. The fill (write minus read, modulo 256) never exceeds the depth, including after a wrap.
- R5: A push into a full buffer is dropped and leaves the pointers unchanged. It sets that buffer's sticky overflow bit, which is bit 5 of its status word.
- R6: A pop from an empty buffer returns zero and leaves both pointers unchanged.
- R7: The interrupt-status bit (control bit 1) is set by a `fw_ring` pulse. Writing 1 to bit 1 clears it, and writing 0 there leaves it set.
- R8: `host_irq` is high exactly when the interrupt-enable bit (control bit 0) is set and interrupt status is pending.
- R9: Writing 1 to the doorbell-generate bit (control bit 2) drives `fw_doorbell` high for exactly the next cycle. Bit 2 always reads back as 0.
- R10: A write with reset=1 (control bit 4) from LNK_IDLE or LNK_READY enters LNK_RESET. It sets pointers of both buffers to zero, clears both overflow bits and reads back ready=0. A further write with reset=1 while already in LNK_RESET leaves the pointers untouched.
- R11: The ready bit (control bit 3) reads 1 only in LNK_READY. A write carrying both reset=1 and ready=1 leaves ready at 0.
- R12: Writing reset=0 together with doorbell-generate=1 while in LNK_RESET releases reset to LNK_IDLE and rings the firmware doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register bus write strobe |
| reg_rd | input | 1 | Register bus read strobe (reads of address 1 pop) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| host_irq | output | 1 | Interrupt to the host |
| fw_push | input | 1 | Firmware pushes a dword toward the host |
| fw_push_data | input | 32 | Dword pushed by the firmware |
| fw_pop | input | 1 | Firmware pops a host dword |
| fw_pop_data | output | 32 | Head dword of the host-to-firmware buffer, zero when empty |
| fw_msg_avail | output | 1 | Host-to-firmware buffer is not empty |
| fw_ready | input | 1 | Firmware ready level |
| fw_ring | input | 1 | Firmware doorbell pulse to the host |
| fw_doorbell | output | 1 | One-cycle doorbell pulse to the firmware |

## Verification
The hardest state to reach from the ports is a pointer pair that has wrapped past 255 while the buffer still holds data. Reaching it takes several hundred push/pop pairs after a flushed start, followed by more pushes without pops. The bench then checks that the reported pointers carry the wrapped values and that the FIFO order still holds. The second awkward case is a reset request repeated while reset is already held, with data queued in between. Telling a flush apart from a no-op requires non-zero pointers at the moment of the second write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int PTR_W  = 8;
    localparam int DATA_W = 32;

    // register word addresses
    localparam logic [1:0] ADDR_H2F_WIN = 2'd0;
    localparam logic [1:0] ADDR_F2H_WIN = 2'd1;
    localparam logic [1:0] ADDR_HCTRL   = 2'd2;
    localparam logic [1:0] ADDR_FVIEW   = 2'd3;

    // control word bit positions
    localparam int BIT_IE  = 0;
    localparam int BIT_IS  = 1;
    localparam int BIT_IG  = 2;
    localparam int BIT_RDY = 3;
    localparam int BIT_RST = 4;
    localparam int BIT_OVF = 5;
    localparam int CTL_W   = 5;

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,
        LNK_READY = 2'd1,
        LNK_RESET = 2'd2
    } link_state_e;

endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int PW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic          ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] fill;
    logic          full;
    logic          empty;

    assign fill  = wptr - rptr;
    assign full  = (fill == DEPTH_P);
    assign empty = (fill == '0);

    always_ff @(posedge clk) begin
        if (push && !full && !flush) begin
            mem[wptr[AW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else begin
            if (push) begin
                if (full) begin
                    ovf <= 1'b1;
                end else begin
                    wptr <= wptr + 1'b1;
                end
            end
            if (pop && !empty) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    assign pop_data = empty ? '0 : mem[rptr[AW-1:0]];

endmodule

// File: rtl/mbx_host_ctrl.sv
module mbx_host_ctrl
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CTL_W-1:0] csr_wdata,
    input  logic             fw_ring,
    output logic             flush,
    output logic             ie,
    output logic             is_pend,
    output logic             reset_bit,
    output logic             ready_bit,
    output logic             doorbell,
    output logic             irq
);
    link_state_e state_q, state_d;

    logic w_rst, w_rdy;
    assign w_rst = csr_wdata[BIT_RST];
    assign w_rdy = csr_wdata[BIT_RDY];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE, LNK_READY: begin
                if (csr_wr) begin
                    if (w_rst)      state_d = LNK_RESET;
                    else if (w_rdy) state_d = LNK_READY;
                    else            state_d = LNK_IDLE;
                end
            end
            LNK_RESET: begin
                if (csr_wr && !w_rst) begin
                    state_d = w_rdy ? LNK_READY : LNK_IDLE;
                end
            end
            default: state_d = LNK_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        flush     = 1'b0;
        reset_bit = 1'b0;
        ready_bit = 1'b0;
        unique case (state_q)
            LNK_IDLE:  flush = csr_wr && w_rst;
            LNK_READY: begin
                ready_bit = 1'b1;
                flush     = csr_wr && w_rst;
            end
            LNK_RESET: reset_bit = 1'b1;
            default: ;
        endcase
    end

    // enable, pending cause and doorbell pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie       <= 1'b0;
            is_pend  <= 1'b0;
            doorbell <= 1'b0;
        end else begin
            doorbell <= csr_wr && csr_wdata[BIT_IG];
            if (csr_wr) ie <= csr_wdata[BIT_IE];
            if (fw_ring)                         is_pend <= 1'b1;
            else if (csr_wr && csr_wdata[BIT_IS]) is_pend <= 1'b0;
        end
    end

    assign irq = ie && is_pend;

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              host_irq,
    input  logic              fw_push,
    input  logic [DATA_W-1:0] fw_push_data,
    input  logic              fw_pop,
    output logic [DATA_W-1:0] fw_pop_data,
    output logic              fw_msg_avail,
    input  logic              fw_ready,
    input  logic              fw_ring,
    output logic              fw_doorbell
);
    localparam int NRING = 2;  // 0: host to firmware, 1: firmware to host
    localparam logic [PTR_W-1:0] DEPTH_F = PTR_W'(DEPTH);

    logic              rg_push      [NRING];
    logic [DATA_W-1:0] rg_push_data [NRING];
    logic              rg_pop       [NRING];
    logic [DATA_W-1:0] rg_pop_data  [NRING];
    logic [PTR_W-1:0]  rg_wptr      [NRING];
    logic [PTR_W-1:0]  rg_rptr      [NRING];
    logic              rg_ovf       [NRING];

    logic hs_flush, hs_ie, hs_is, hs_rst, hs_rdy, ctl_wr;

    assign ctl_wr = reg_wr && (reg_addr == ADDR_HCTRL);

    assign rg_push[0]      = reg_wr && (reg_addr == ADDR_H2F_WIN);
    assign rg_push_data[0] = reg_wdata;
    assign rg_pop[0]       = fw_pop;
    assign rg_push[1]      = fw_push;
    assign rg_push_data[1] = fw_push_data;
    assign rg_pop[1]       = reg_rd && (reg_addr == ADDR_F2H_WIN);

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        mbx_ring #(
            .DEPTH (DEPTH),
            .DW    (DATA_W),
            .PW    (PTR_W)
        ) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (hs_flush),
            .push      (rg_push[g]),
            .push_data (rg_push_data[g]),
            .pop       (rg_pop[g]),
            .pop_data  (rg_pop_data[g]),
            .wptr      (rg_wptr[g]),
            .rptr      (rg_rptr[g]),
            .ovf       (rg_ovf[g])
        );
    end

    mbx_host_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (ctl_wr),
        .csr_wdata (reg_wdata[CTL_W-1:0]),
        .fw_ring   (fw_ring),
        .flush     (hs_flush),
        .ie        (hs_ie),
        .is_pend   (hs_is),
        .reset_bit (hs_rst),
        .ready_bit (hs_rdy),
        .doorbell  (fw_doorbell),
        .irq       (host_irq)
    );

    assign fw_pop_data  = rg_pop_data[0];
    assign fw_msg_avail = (rg_wptr[0] != rg_rptr[0]);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_H2F_WIN: reg_rdata = '0;
            ADDR_F2H_WIN: reg_rdata = rg_pop_data[1];
            ADDR_HCTRL:   reg_rdata = {DEPTH_F, rg_wptr[0], rg_rptr[0], 2'b00,
                                       rg_ovf[0], hs_rst, hs_rdy, 1'b0, hs_is, hs_ie};
            ADDR_FVIEW:   reg_rdata = {DEPTH_F, rg_wptr[1], rg_rptr[1], 2'b00,
                                       rg_ovf[1], 1'b0, fw_ready, 3'b000};
            default:      reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [4:0]  wlow,
    input logic        fw_doorbell,
    input logic        is_pend,
    input logic        reset_bit,
    input logic [7:0]  w0,
    input logic [7:0]  r0,
    input logic [7:0]  w1,
    input logic [7:0]  r1
);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    logic [7:0] fill0, fill1;
    assign fill0 = w0 - r0;
    assign fill1 = w1 - r1;

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (fill0 <= DEPTH_B) && (fill1 <= DEPTH_B)); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && fill0 == DEPTH_B) |=> (w0 == $past(w0))); // R5

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 2'd1 && w1 == r1) |=> (r1 == $past(r1))); // R6

    AST_IS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pend && !(reg_wr && reg_addr == 2'd2 && wlow[1])) |=> is_pend); // R7

    AST_DOORBELL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fw_doorbell |-> $past(reg_wr && reg_addr == 2'd2 && wlow[2])); // R9

    AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && wlow[4] && !reset_bit)
        |=> (w0 == 8'd0 && r0 == 8'd0 && w1 == 8'd0 && r1 == 8'd0)); // R10

endmodule

bind mbx_doorbell mbx_doorbell_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .wlow        (reg_wdata[4:0]),
    .fw_doorbell (fw_doorbell),
    .is_pend     (hs_is),
    .reset_bit   (hs_rst),
    .w0          (rg_wptr[0]),
    .r0          (rg_rptr[0]),
    .w1          (rg_wptr[1]),
    .r1          (rg_rptr[1])
);

// File: tb/mbx_doorbell_tb.sv
`timescale 1ns/1ps
module mbx_doorbell_tb;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_FPUSH = 2'd2, OP_FPOP = 2'd3;
    localparam int NVEC = 15;
    // {op, addr, data, expected}
    localparam logic [67:0] VECS [NVEC] = '{
        {OP_RD,    2'd2, 32'h0,  32'h1000_0000},  // R1 host word after reset
        {OP_RD,    2'd3, 32'h0,  32'h1000_0000},  // R1 firmware view after reset
        {OP_WR,    2'd0, 32'hA1, 32'h0},          // R2 push
        {OP_WR,    2'd0, 32'hB2, 32'h0},          // R2 push
        {OP_RD,    2'd2, 32'h0,  32'h1002_0000},  // R2 wptr=2
        {OP_FPOP,  2'd0, 32'h0,  32'h0000_00A1},  // R2 order
        {OP_FPOP,  2'd0, 32'h0,  32'h0000_00B2},  // R2 order
        {OP_FPOP,  2'd0, 32'h0,  32'h0},          // R6 empty pop
        {OP_RD,    2'd2, 32'h0,  32'h1002_0200},  // R6 pointers held
        {OP_FPUSH, 2'd0, 32'hC3, 32'h0},          // R3 fw push
        {OP_RD,    2'd1, 32'h0,  32'h0000_00C3},  // R3 host pop
        {OP_RD,    2'd1, 32'h0,  32'h0},          // R6 empty host pop
        {OP_RD,    2'd3, 32'h0,  32'h1001_0100},  // R3 firmware view
        {OP_WR,    2'd2, 32'h1,  32'h0},          // R8 enable
        {OP_RD,    2'd2, 32'h0,  32'h1002_0201}   // R8 enable reads back
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;
    logic        fw_push = 1'b0;
    logic [31:0] fw_push_data = '0;
    logic        fw_pop = 1'b0;
    logic [31:0] fw_pop_data;
    logic        fw_msg_avail;
    logic        fw_ready = 1'b0;
    logic        fw_ring = 1'b0;
    logic        fw_doorbell;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mbx_doorbell #(.DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq(host_irq), .fw_push(fw_push), .fw_push_data(fw_push_data),
        .fw_pop(fw_pop), .fw_pop_data(fw_pop_data), .fw_msg_avail(fw_msg_avail),
        .fw_ready(fw_ready), .fw_ring(fw_ring), .fw_doorbell(fw_doorbell)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic fw_put(input logic [31:0] d);
        fw_push = 1'b1; fw_push_data = d;
        @(negedge clk);
        fw_push = 1'b0;
    endtask

    task automatic fw_get(output logic [31:0] d);
        fw_pop = 1'b1;
        #1 d = fw_pop_data;
        @(negedge clk);
        fw_pop = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state of outputs (R1, R8, R9)
        chk("R8 reset irq", {31'd0, host_irq}, 32'd0);
        chk("R9 reset doorbell", {31'd0, fw_doorbell}, 32'd0);
        chk("R2 reset avail", {31'd0, fw_msg_avail}, 32'd0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [1:0]  ad;
            logic [31:0] dd, ex;
            {op, ad, dd, ex} = VECS[i];
            unique case (op)
                OP_WR:    host_wr(ad, dd);
                OP_RD:    begin host_rd(ad, v); chk($sformatf("table[%0d]", i), v, ex); end
                OP_FPUSH: fw_put(dd);
                OP_FPOP:  begin fw_get(v); chk($sformatf("table[%0d]", i), v, ex); end
                default: ;
            endcase
        end

        // R1 firmware ready bit 3 in the firmware view
        fw_ready = 1'b1;
        host_rd(2'd3, v);
        chk("R1 fw ready bit", v, 32'h1001_0108);
        fw_ready = 1'b0;

        // R7 / R8 interrupt status and enable
        fw_ring = 1'b1; @(negedge clk); fw_ring = 1'b0;
        host_rd(2'd2, v);
        chk("R7 status set", {31'd0, v[1]}, 32'd1);
        chk("R8 irq raised", {31'd0, host_irq}, 32'd1);
        host_wr(2'd2, 32'h1);
        host_rd(2'd2, v);
        chk("R7 zero write keeps", {31'd0, v[1]}, 32'd1);
        host_wr(2'd2, 32'h0);
        chk("R8 irq masked", {31'd0, host_irq}, 32'd0);
        host_wr(2'd2, 32'h3);
        host_rd(2'd2, v);
        chk("R7 one write clears", {31'd0, v[1]}, 32'd0);
        chk("R8 irq after clear", {31'd0, host_irq}, 32'd0);

        // R9 doorbell pulse
        host_wr(2'd2, 32'h5);
        chk("R9 pulse high", {31'd0, fw_doorbell}, 32'd1);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'd0, fw_doorbell}, 32'd0);
        host_rd(2'd2, v);
        chk("R9 ig reads zero", {31'd0, v[2]}, 32'd0);

        // R5 overflow: 16 pushes fill the buffer (wptr 2 -> 18), one more dropped
        for (int k = 0; k < 16; k++) host_wr(2'd0, 32'h100 + k);
        host_wr(2'd0, 32'hDEAD);
        host_rd(2'd2, v);
        chk("R5 wptr held", {24'd0, v[23:16]}, 32'h12);
        chk("R5 overflow flag", {31'd0, v[5]}, 32'd1);
        fw_get(v);
        chk("R5 head intact", v, 32'h100);

        // R10 reset start flushes
        host_wr(2'd2, 32'h10);
        host_rd(2'd2, v);
        chk("R10 host word flushed", v, 32'h1000_0010);
        host_rd(2'd3, v);
        chk("R10 fw view flushed", v, 32'h1000_0000);
        for (int k = 0; k < 3; k++) host_wr(2'd0, 32'h200 + k);
        host_wr(2'd2, 32'h10);
        host_rd(2'd2, v);
        chk("R10 repeated reset ignored", v, 32'h1003_0010);

        // R11 ready refused while reset requested
        host_wr(2'd2, 32'h18);
        host_rd(2'd2, v);
        chk("R11 ready held low", v, 32'h1003_0010);

        // R12 release with doorbell
        host_wr(2'd2, 32'h04);
        chk("R12 doorbell on release", {31'd0, fw_doorbell}, 32'd1);
        host_rd(2'd2, v);
        chk("R12 reset released", v, 32'h1003_0000);

        // R11 ready, then R10 reset from ready clears it
        host_wr(2'd2, 32'h08);
        host_rd(2'd2, v);
        chk("R11 ready set", v, 32'h1003_0008);
        host_wr(2'd2, 32'h18);
        host_rd(2'd2, v);
        chk("R10 reset from ready", v, 32'h1000_0010);
        host_wr(2'd2, 32'h00);

        // R4 pointer wrap: 300 push/pop pairs, then 3 more pushes
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            host_wr(2'd0, 32'h5000 + k);
            fw_get(v);
            if (v !== 32'h5000 + k) bad++;
        end
        chk("R4 order across wrap", bad, 0);
        host_rd(2'd2, v);
        chk("R4 wrapped pointers", v, 32'h102C_2C00);
        for (int k = 0; k < 3; k++) host_wr(2'd0, 32'h6000 + k);
        host_rd(2'd2, v);
        chk("R4 fill after wrap", {24'd0, v[23:16] - v[15:8]}, 32'd3);
        chk("R2 avail after wrap", {31'd0, fw_msg_avail}, 32'd1);
        fw_get(v);
        chk("R4 head after wrap", v, 32'h6000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule